// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a parameterised general-purpose I/O port (eight pins by default) with its own interrupt logic, reached through a plain single-cycle register bus. Each pin has an output latch and a drive-enable bit. Every pin input passes through a two-stage synchronizer. After that it can optionally go through a debounce filter, selected per pin.

Interrupt detection is set per pin by two independent bits. One bit chooses level or edge sensing. The other chooses the active sense: low or falling, against high or rising. An edge that matches the chosen sense sets a sticky pending flag. That flag stays set until software writes a one to the pin's bit in the end-of-interrupt register. In level mode the pending condition simply follows the input.

A per-pin enable masks the pending conditions into a status byte. The single interrupt request output is the OR of that byte. Software reconfigures a pin by first clearing its enable, then rewriting its type bits, then restoring the enable.

Top module: `gpirq_port`

## Requirements
- R1: After reset every register reads 0, no pin is driven (`pin_oe` = 0), `irq_status` = 0 and `irq_out` = 0.
- R2: `pin_out` equals the data register (offset 0x00) and `pin_oe` equals the direction register (offset 0x10, bit 1 = drive). A read of offset 0x00 returns the data register bit for driven pins and the synchronized pin input for undriven pins.
- R3: Writing a byte to the end-of-interrupt register (offset 0x98) clears the latched edge of every pin whose bit is 1. Pins written with 0 keep their latched edge. The register reads as 0.
- R4: If a new qualifying edge and an end-of-interrupt clear for the same pin land in the same cycle, the pin stays pending.
- R5: Bit i of the sense-mode register (offset 0x90) set to 0 makes pin i level-sensitive. In that mode its pending condition follows the input with no latching, and end-of-interrupt writes do not affect it. Set to 1, the pin is edge-sensitive.
- R6: Bit i of the polarity register (offset 0x94) set to 0 selects active-low (level) or falling (edge). Set to 1, it selects active-high (level) or rising (edge). An edge of the opposite direction sets nothing.
- R7: With its debounce bit (offset 0xA8) set, a pin's filtered input changes only after the synchronized input has differed from it for DB_TICKS consecutive cycles, so a shorter pulse causes no event. Without debounce, an edge is pending three clock edges after the pin changes; with debounce, DB_TICKS edges later.
- R8: `irq_status` bit i is pin i's pending condition ANDed with enable bit i (offset 0x9C). The same byte reads at offset 0xA0, and writes to offset 0xA0 are ignored.
- R9: `irq_out` is high exactly when any `irq_status` bit is high.
- R10: The mode, polarity, enable and debounce registers read back the last value written, and an unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| pin_in | input | WIDTH | Asynchronous pin inputs |
| pin_out | output | WIDTH | Pin output values |
| pin_oe | output | WIDTH | Pin drive enables, 1 = drive |
| irq_status | output | WIDTH | Enabled pending conditions, one bit per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
Random pin transitions are applied under random mixes of sense mode, polarity, enable and debounce. Each transition is given time to settle, so the bench separates rising from falling qualification and latched from level-following pins. Random end-of-interrupt bytes show that clearing touches only the written edge pins. Directed cases cover the rest: a short pulse with and without debounce (filter against raw path), the exact cycle an edge first appears (pipeline depth), and an edge colliding with its own clear (priority).

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;

  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 8'h90;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h94;
  localparam logic [ADDR_W-1:0] OFS_EOI   = 8'h98;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h9C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'hA0;
  localparam logic [ADDR_W-1:0] OFS_DBN   = 8'hA8;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_POL,
    SEL_EOI,
    SEL_IEN,
    SEL_STAT,
    SEL_DBN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DATA:  return SEL_DATA;
      OFS_DIR:   return SEL_DIR;
      OFS_SENSE: return SEL_SENSE;
      OFS_POL:   return SEL_POL;
      OFS_EOI:   return SEL_EOI;
      OFS_IEN:   return SEL_IEN;
      OFS_STAT:  return SEL_STAT;
      OFS_DBN:   return SEL_DBN;
      default:   return SEL_NONE;
    endcase
  endfunction

  // active level: pol=1 means high is active, pol=0 means low is active
  function automatic logic level_active(input logic v, input logic pol);
    return pol ? v : ~v;
  endfunction

  // qualifying transition: input moved and now sits at the active level
  function automatic logic edge_seen(input logic prev, input logic cur, input logic pol);
    return (prev != cur) && (cur == pol);
  endfunction

endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpirq_filter.sv
module gpirq_filter #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned DB_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_in,
  input  logic [WIDTH-1:0] dbn_en,
  output logic [WIDTH-1:0] filt_q,
  output logic [WIDTH-1:0] level_out
);

  localparam int unsigned CNT_W = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_TICKS - 1);

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [CNT_W-1:0] cnt_q;
    logic             flt_q;
    logic             differs;

    assign differs = sync_in[g] != flt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        flt_q <= 1'b0;
      end else if (!dbn_en[g]) begin
        // filter disabled: track the raw level so enabling it is glitch-free
        cnt_q <= '0;
        flt_q <= sync_in[g];
      end else if (!differs) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        flt_q <= sync_in[g];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign filt_q[g]    = flt_q;
    assign level_out[g] = dbn_en[g] ? flt_q : sync_in[g];
  end

endmodule

// File: rtl/gpirq_detect.sv
module gpirq_detect #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] sense_edge,
  input  logic [WIDTH-1:0] pol_high,
  input  logic [WIDTH-1:0] eoi_clr,
  output logic [WIDTH-1:0] edge_evt,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] raw_pend
);

  import gpirq_pkg::*;

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= level_in;
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    assign edge_evt[g] = sense_edge[g] & edge_seen(prev_q[g], level_in[g], pol_high[g]);

    // a new edge takes priority over a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[g] <= 1'b0;
      end else begin
        latch_q[g] <= sense_edge[g] & (edge_evt[g] | (latch_q[g] & ~eoi_clr[g]));
      end
    end

    assign raw_pend[g] = sense_edge[g] ? latch_q[g]
                                       : level_active(level_in[g], pol_high[g]);
  end

endmodule

// File: rtl/gpirq_regs.sv
module gpirq_regs #(
  parameter int unsigned WIDTH = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_we,
  input  logic [gpirq_pkg::ADDR_W-1:0]    bus_addr,
  input  logic [WIDTH-1:0]                bus_wdata,
  output logic [WIDTH-1:0]                bus_rdata,
  input  logic [WIDTH-1:0]                sync_in,
  input  logic [WIDTH-1:0]                status,
  output logic [WIDTH-1:0]                data_q,
  output logic [WIDTH-1:0]                dir_q,
  output logic [WIDTH-1:0]                sense_q,
  output logic [WIDTH-1:0]                pol_q,
  output logic [WIDTH-1:0]                ien_q,
  output logic [WIDTH-1:0]                dbn_q,
  output logic [WIDTH-1:0]                eoi_pulse
);

  import gpirq_pkg::*;

  reg_sel_e sel;
  assign sel = decode_addr(bus_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      sense_q <= '0;
      pol_q   <= '0;
      ien_q   <= '0;
      dbn_q   <= '0;
    end else if (bus_we) begin
      case (sel)
        SEL_DATA:  data_q  <= bus_wdata;
        SEL_DIR:   dir_q   <= bus_wdata;
        SEL_SENSE: sense_q <= bus_wdata;
        SEL_POL:   pol_q   <= bus_wdata;
        SEL_IEN:   ien_q   <= bus_wdata;
        SEL_DBN:   dbn_q   <= bus_wdata;
        default:   ;
      endcase
    end
  end

  assign eoi_pulse = (bus_we && sel == SEL_EOI) ? bus_wdata : '0;

  always_comb begin
    case (sel)
      SEL_DATA:  bus_rdata = (dir_q & data_q) | (~dir_q & sync_in);
      SEL_DIR:   bus_rdata = dir_q;
      SEL_SENSE: bus_rdata = sense_q;
      SEL_POL:   bus_rdata = pol_q;
      SEL_IEN:   bus_rdata = ien_q;
      SEL_STAT:  bus_rdata = status;
      SEL_DBN:   bus_rdata = dbn_q;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpirq_port.sv
module gpirq_port #(
  parameter int unsigned WIDTH    = 8,
  parameter int unsigned DB_TICKS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_we,
  input  logic [gpirq_pkg::ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]             bus_wdata,
  output logic [WIDTH-1:0]             bus_rdata,
  input  logic [WIDTH-1:0]             pin_in,
  output logic [WIDTH-1:0]             pin_out,
  output logic [WIDTH-1:0]             pin_oe,
  output logic [WIDTH-1:0]             irq_status,
  output logic                         irq_out
);

  // named internal events, also observed by the bound checker
  logic [WIDTH-1:0] sync_lvl;
  logic [WIDTH-1:0] filt_lvl;
  logic [WIDTH-1:0] use_lvl;
  logic [WIDTH-1:0] sense_bits;
  logic [WIDTH-1:0] pol_bits;
  logic [WIDTH-1:0] ien_bits;
  logic [WIDTH-1:0] dbn_bits;
  logic [WIDTH-1:0] eoi_clr;
  logic [WIDTH-1:0] edge_evt;
  logic [WIDTH-1:0] edge_latch;
  logic [WIDTH-1:0] raw_pend;

  gpirq_sync #(.WIDTH(WIDTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (sync_lvl)
  );

  gpirq_filter #(.WIDTH(WIDTH), .DB_TICKS(DB_TICKS)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_in   (sync_lvl),
    .dbn_en    (dbn_bits),
    .filt_q    (filt_lvl),
    .level_out (use_lvl)
  );

  gpirq_detect #(.WIDTH(WIDTH)) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_in   (use_lvl),
    .sense_edge (sense_bits),
    .pol_high   (pol_bits),
    .eoi_clr    (eoi_clr),
    .edge_evt   (edge_evt),
    .latch_q    (edge_latch),
    .raw_pend   (raw_pend)
  );

  gpirq_regs #(.WIDTH(WIDTH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .sync_in   (sync_lvl),
    .status    (irq_status),
    .data_q    (pin_out),
    .dir_q     (pin_oe),
    .sense_q   (sense_bits),
    .pol_q     (pol_bits),
    .ien_q     (ien_bits),
    .dbn_q     (dbn_bits),
    .eoi_pulse (eoi_clr)
  );

  assign irq_status = raw_pend & ien_bits;
  assign irq_out    = |irq_status;

endmodule

// File: rtl/gpirq_port_chk.sv
module gpirq_port_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] sync_lvl,
  input logic [WIDTH-1:0] filt_lvl,
  input logic [WIDTH-1:0] dbn_bits,
  input logic [WIDTH-1:0] sense_bits,
  input logic [WIDTH-1:0] eoi_clr,
  input logic [WIDTH-1:0] edge_evt,
  input logic [WIDTH-1:0] edge_latch,
  input logic [WIDTH-1:0] pin_oe,
  input logic [WIDTH-1:0] irq_status,
  input logic             irq_out
);

  // R3: a cleared edge pin with no new edge is not pending next cycle
  a_r3_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_latch & $past(edge_latch & eoi_clr & ~edge_evt)) == '0));

  // R4: a detected edge always leaves the pin pending, clear or not
  a_r4_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_latch & $past(edge_evt)) == $past(edge_evt)));

  // R5: a level-sensitive pin never holds a latched edge
  a_r5_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_latch & ~$past(sense_bits)) == '0));

  // R7: a debounced pin only moves to the value its synchronized input held
  a_r7_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((filt_lvl ^ $past(filt_lvl)) & $past(dbn_bits) & (filt_lvl ^ $past(sync_lvl))) == '0));

  // R1: nothing driven and no request right after reset
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && !irq_out));

  // R9: the combined request tracks the status byte
  a_r9_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (irq_status != '0));

endmodule

bind gpirq_port gpirq_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_lvl   (sync_lvl),
  .filt_lvl   (filt_lvl),
  .dbn_bits   (dbn_bits),
  .sense_bits (sense_bits),
  .eoi_clr    (eoi_clr),
  .edge_evt   (edge_evt),
  .edge_latch (edge_latch),
  .pin_oe     (pin_oe),
  .irq_status (irq_status),
  .irq_out    (irq_out)
);

// File: tb/gpirq_port_test.sv
module gpirq_port_test;

  localparam int unsigned W     = 8;
  localparam int unsigned DB    = 4;
  localparam time         CYC   = 20ns;
  localparam int unsigned SETTLE = DB + 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] pin_out;
  logic [W-1:0] pin_oe;
  logic [W-1:0] irq_status;
  logic         irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the register state
  logic [W-1:0] m_data, m_dir, m_sense, m_pol, m_ien, m_dbn, m_latch, m_pins;

  gpirq_port #(.WIDTH(W), .DB_TICKS(DB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_status(irq_status), .irq_out(irq_out)
  );

  always #(CYC/2) clk = ~clk;

  function automatic logic [W-1:0] exp_status();
    logic [W-1:0] lvl;
    lvl = ~(m_pol ^ m_pins);
    return m_ien & ((m_sense & m_latch) | (~m_sense & lvl));
  endfunction

  function automatic logic [W-1:0] exp_data_read();
    return (m_dir & m_data) | (~m_dir & m_pins);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // change the pins, let them settle, update the model's latched edges
  task automatic move_pins(input logic [W-1:0] nv);
    logic [W-1:0] chg;
    @(negedge clk);
    chg = nv ^ m_pins;
    pin_in = nv;
    m_latch = m_latch | (chg & m_sense & ~(nv ^ m_pol));
    m_pins = nv;
    wait_cycles(SETTLE);
  endtask

  task automatic set_cfg(input logic [W-1:0] s, input logic [W-1:0] p,
                         input logic [W-1:0] e, input logic [W-1:0] d);
    bus_write(8'h9C, '0);
    bus_write(8'h90, s);
    bus_write(8'h94, p);
    bus_write(8'hA8, d);
    bus_write(8'h9C, e);
    m_sense = s; m_pol = p; m_ien = e; m_dbn = d;
    m_latch = m_latch & s;
  endtask

  task automatic eoi(input logic [W-1:0] v);
    bus_write(8'h98, v);
    m_latch = m_latch & ~v;
  endtask

  initial begin
    #(CYC * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] rd;
    logic [W-1:0] r;
    r = W'($urandom(32'd20240611));
    m_data = '0; m_dir = '0; m_sense = '0; m_pol = '0;
    m_ien = '0; m_dbn = '0; m_latch = '0; m_pins = '0;

    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(2);

    // R1: reset state
    check("R1 pin_oe", pin_oe, 0);
    check("R1 irq_status", irq_status, 0);
    check("R1 irq_out", irq_out, 0);
    bus_read(8'h90, rd); check("R1 sense reg", rd, 0);
    bus_read(8'h9C, rd); check("R1 enable reg", rd, 0);

    // R10: readback and unmapped offsets
    bus_write(8'hA8, 8'h5A); bus_read(8'hA8, rd); check("R10 debounce readback", rd, 8'h5A);
    bus_write(8'hA8, 8'h00);
    bus_read(8'h44, rd); check("R10 unmapped reads 0", rd, 0);
    bus_read(8'h98, rd); check("R3 eoi reads 0", rd, 0);

    // R2: data and direction
    bus_write(8'h00, 8'hC3); bus_write(8'h10, 8'hF0);
    m_data = 8'hC3; m_dir = 8'hF0;
    move_pins(8'h0A);
    check("R2 pin_out", pin_out, 8'hC3);
    check("R2 pin_oe", pin_oe, 8'hF0);
    bus_read(8'h00, rd); check("R2 data read mix", rd, exp_data_read());

    // R5/R6: level mode follows input, eoi no effect
    set_cfg(8'h00, 8'h0F, 8'hFF, 8'h00);
    check("R5 R6 level status", irq_status, exp_status());
    eoi(8'hFF);
    check("R5 eoi ignored on level pins", irq_status, exp_status());
    move_pins(8'hF5);
    check("R5 level follows input", irq_status, exp_status());
    check("R9 irq or", irq_out, exp_status() != 0);

    // R6: rising vs falling, opposite direction ignored
    set_cfg(8'hFF, 8'h0F, 8'hFF, 8'h00);
    eoi(8'hFF);
    move_pins(8'h00);
    check("R6 falling on rising-only pins", irq_status, exp_status());
    move_pins(8'hFF);
    check("R6 rising edges", irq_status, exp_status());
    eoi(8'h33);
    check("R3 partial eoi", irq_status, exp_status());

    // R8: status write ignored, status readable
    bus_write(8'hA0, 8'hFF);
    bus_read(8'hA0, rd); check("R8 status read", rd, exp_status());
    set_cfg(8'hFF, 8'h0F, 8'h0F, 8'h00);
    check("R8 enable masks status", irq_status, exp_status());

    // R7: exact latency without debounce (pin 0 rising)
    set_cfg(8'hFF, 8'hFF, 8'hFF, 8'h00);
    move_pins(8'h00); eoi(8'hFF);
    @(negedge clk); pin_in = 8'h01;
    wait_cycles(2); check("R7 no edge after two edges", irq_status[0], 0);
    wait_cycles(1); check("R7 edge on third edge", irq_status[0], 1);
    m_pins = 8'h01; m_latch = 8'h01;
    wait_cycles(SETTLE);

    // R7: latency with debounce (pin 1 rising)
    set_cfg(8'hFF, 8'hFF, 8'hFF, 8'hFF);
    eoi(8'hFF);
    @(negedge clk); pin_in = 8'h03;
    wait_cycles(2 + DB); check("R7 debounced not yet", irq_status[1], 0);
    wait_cycles(1); check("R7 debounced edge", irq_status[1], 1);
    m_pins = 8'h03; m_latch = 8'h02;
    wait_cycles(SETTLE);

    // R7: short pulse suppressed with debounce, seen without
    eoi(8'hFF);
    @(negedge clk); pin_in = 8'h07;
    wait_cycles(DB - 1); pin_in = 8'h03;
    wait_cycles(SETTLE);
    check("R7 short pulse filtered", irq_status[2], 0);
    set_cfg(8'hFF, 8'hFF, 8'hFF, 8'h00);
    @(negedge clk); pin_in = 8'h07;
    wait_cycles(2); pin_in = 8'h03;
    wait_cycles(SETTLE);
    check("R7 short pulse seen raw", irq_status[2], 1);
    m_latch = m_latch | 8'h04;

    // R4: edge collides with its own clear
    set_cfg(8'hFF, 8'hFF, 8'hFF, 8'h00);
    eoi(8'hFF);
    move_pins(8'h08); move_pins(8'h00);
    check("R4 precondition pending", irq_status[3], 1);
    @(negedge clk); pin_in = 8'h08;
    wait_cycles(2);
    bus_addr = 8'h98; bus_wdata = 8'h08; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    check("R4 edge wins over eoi", irq_status[3], 1);
    eoi(8'h08);
    check("R3 eoi clears edge", irq_status[3], 0);
    m_pins = 8'h08; m_latch = 8'h00;

    // random mix
    for (int it = 0; it < 80; it++) begin
      if ($urandom_range(0, 2) == 0)
        set_cfg(W'($urandom), W'($urandom), W'($urandom), W'($urandom));
      move_pins(W'($urandom));
      if ($urandom_range(0, 1) == 0) eoi(W'($urandom));
      check("R3 R5 R6 R8 random status", irq_status, exp_status());
      check("R9 random irq", irq_out, exp_status() != 0);
      if (it % 8 == 0) begin
        bus_read(8'hA0, rd); check("R8 random status read", rd, exp_status());
        bus_read(8'h00, rd); check("R2 random data read", rd, exp_data_read());
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule